// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block watches a bank of interrupt request lines, remembers every new request as pending, and picks one of them to offer to a processor core. Software programs the block through a small write port. For each line it can set an enable bit and a 4-bit urgency value. It can also set a grouping value, which marks how many upper bits of every urgency value count toward preemption. A masking threshold shuts out the less urgent requests. On the core side the block drives a request flag and the number of the winning line. It accepts an acknowledge when the core starts a handler and an end-of-service when the handler finishes.

A smaller urgency value is more urgent. The block keeps a small stack holding the preemption level of each handler in service. A new request interrupts the running handler only when its preemption field is strictly smaller than the level on top of the stack. The low subpriority bits only decide between requests that are otherwise equal. End-of-service pops the stack, so the level that was interrupted is in force again. Saving the core's registers and fetching handler addresses are outside this block.

Top module: `npic_top`

## Requirements
- R1: After reset, `irq_req` is 0 and `irq_vec` is 0. After reset no line is pending, every line is disabled, every urgency value is 0, the threshold is 0, the grouping is 4 and no handler is in service.
- R2: A line becomes pending on the first clock edge at which its input is high after being low. This happens whether or not the line is enabled. A line that stays high does not become pending again after its pending bit is cleared.
- R3: A disabled line is never presented. Enabling a pending line makes it eligible.
- R4: Among pending, enabled, unmasked lines the winner has the smallest full urgency value. If two lines have equal values, the lower line number wins. When a winner is allowed, `irq_req` is 1 and `irq_vec` is its line number.
- R5: With threshold T nonzero, a line whose urgency value is greater than or equal to T is blocked. With T = 0 nothing is blocked.
- R6: An `ack` while `irq_req` is 1 clears the pending bit of `irq_vec` and pushes that line's preemption level onto the stack. An `ack` while `irq_req` is 0 has no effect.
- R7: With a handler in service, a request is presented only if its preemption field is strictly smaller than the running level. An equal value does not preempt.
- R8: The grouping value G (0..4, larger written values clamp to 4) selects the upper G urgency bits as the preemption field. The remaining lower bits never cause preemption. With G = 0 no request preempts a handler in service.
- R9: `eoi` removes the top handler, and the level beneath it, or idle, applies again. An `eoi` with no handler in service has no effect.
- R10: When the stack holds DEPTH (4) handlers, `irq_req` stays 0 until one ends.
- R11: A write on the configuration port affects `irq_req` and `irq_vec` from the next cycle. The write encodings are: `cfg_kind` 0 sets the urgency value of `cfg_line` to `cfg_data`; 1 sets its enable to `cfg_data[0]`; 2 sets grouping to `cfg_data`; 3 sets the threshold to `cfg_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Interrupt request lines, rising edge latches pending |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Which setting is written (see R11) |
| cfg_line | input | 4 | Line addressed by urgency/enable writes |
| cfg_data | input | 4 | Write value |
| ack | input | 1 | Core takes the presented vector |
| eoi | input | 1 | Core finished the top handler |
| irq_req | output | 1 | A request is offered to the core |
| irq_vec | output | 4 | Line number of the winning request |

## Verification
On every cycle the assertions check the following. A presented line is pending, enabled and under the threshold. A presented line beats the running level whenever a handler is in service. Nothing is presented while the stack is full. A rising input always leaves the line pending. The stack depth moves by exactly one on an accepted acknowledge or a valid end-of-service, and never exceeds its limit. Only the bench scenarios can show that the correct line wins a tie and that equal levels do not nest. They also show how grouping changes nesting, that a popped level is really restored, and that ignored acknowledges and end-of-service strobes leave no trace.

// File: rtl/npic_pkg.sv
package npic_pkg;

  typedef enum logic [1:0] {
    CFG_PRIO   = 2'd0,
    CFG_ENABLE = 2'd1,
    CFG_GROUP  = 2'd2,
    CFG_THRESH = 2'd3
  } cfg_kind_e;

  // Keep the upper grp bits of a width-bit urgency value, clear the rest.
  function automatic logic [7:0] preempt_key(input logic [7:0] prio,
                                             input int width, input int grp);
    logic [7:0] k;
    k = '0;
    for (int b = 0; b < 8; b++) begin
      if (b < width && b + grp >= width) k[b] = prio[b];
    end
    return k;
  endfunction

  // True when a nonzero threshold shuts this urgency value out.
  function automatic logic is_masked(input logic [7:0] prio, input logic [7:0] thresh);
    return (thresh != 8'd0) && (prio >= thresh);
  endfunction

endpackage

// File: rtl/npic_pending.sv
module npic_pending #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     irq_in,
  input  logic             clr_valid,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [N-1:0]     pending_o
);

  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] rise;
  logic [N-1:0] clr_vec;

  assign rise    = irq_in & ~prev_q;
  assign clr_vec = clr_valid ? (N'(1) << clr_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= irq_in;
      pend_q <= (pend_q & ~clr_vec) | rise;
    end
  end

  assign pending_o = pend_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_rise_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> pend_q[i])
      else $error("edge on line %0d not latched", i);
  end

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && !rise[clr_idx]) |=> !pend_q[$past(clr_idx)])
    else $error("acknowledged line still pending");

endmodule

// File: rtl/npic_arbiter.sv
module npic_arbiter #(
  parameter int N      = 16,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic [N-1:0]             pending,
  input  logic [N-1:0]             enable,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]        thresh,
  output logic                     found_o,
  output logic [IDX_W-1:0]         win_idx_o,
  output logic [PRIO_W-1:0]        win_prio_o
);
  import npic_pkg::*;

  always_comb begin
    found_o    = 1'b0;
    win_idx_o  = '0;
    win_prio_o = '1;
    for (int i = 0; i < N; i++) begin
      if (pending[i] && enable[i] && !is_masked(8'(prio[i]), 8'(thresh)) &&
          (!found_o || prio[i] < win_prio_o)) begin
        found_o    = 1'b1;
        win_idx_o  = IDX_W'(i);
        win_prio_o = prio[i];
      end
    end
  end

endmodule

// File: rtl/npic_level_stack.sv
module npic_level_stack #(
  parameter int DEPTH  = 4,
  parameter int KEY_W  = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [KEY_W-1:0] push_key,
  output logic [KEY_W-1:0] top_key_o,
  output logic             empty_o,
  output logic             full_o
);

  logic [KEY_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0] depth_q;
  logic             do_pop;
  logic             do_push;
  logic [CNT_W-1:0] after_pop;

  assign empty_o   = (depth_q == '0);
  assign full_o    = (depth_q == CNT_W'(DEPTH));
  assign do_pop    = pop && !empty_o;
  assign after_pop = depth_q - CNT_W'(do_pop);
  assign do_push   = push && (after_pop < CNT_W'(DEPTH));
  assign top_key_o = empty_o ? '0 : mem_q[SLOT_W'(depth_q - 1'b1)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) mem_q[SLOT_W'(after_pop)] <= push_key;
      depth_q <= after_pop + CNT_W'(do_push);
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= CNT_W'(DEPTH))
    else $error("nesting stack overflow");

  p_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty_o && !push) |=> depth_q == CNT_W'($past(depth_q) - 1'b1))
    else $error("end-of-service did not pop");

  p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty_o && !push) |=> empty_o)
    else $error("pop on empty stack changed depth");

  p_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !full_o) |=> depth_q == CNT_W'($past(depth_q) + 1'b1))
    else $error("acknowledge did not push");

endmodule

// File: rtl/npic_top.sv
module npic_top #(
  parameter int N      = 16,
  parameter int PRIO_W = 4,
  parameter int DEPTH  = 4,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [IDX_W-1:0]  cfg_line,
  input  logic [PRIO_W-1:0] cfg_data,
  input  logic              ack,
  input  logic              eoi,
  output logic              irq_req,
  output logic [IDX_W-1:0]  irq_vec
);
  import npic_pkg::*;

  localparam int GRP_W = $clog2(PRIO_W + 1);

  logic [N-1:0][PRIO_W-1:0] prio_q;
  logic [N-1:0]             enable_q;
  logic [GRP_W-1:0]         group_q;
  logic [PRIO_W-1:0]        thresh_q;

  logic [N-1:0]      pending;
  logic              found;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio;
  logic [PRIO_W-1:0] win_key;
  logic [PRIO_W-1:0] top_key;
  logic              stk_empty;
  logic              stk_full;
  logic              beats_running;
  logic              accept;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q   <= '0;
      enable_q <= '0;
      group_q  <= GRP_W'(PRIO_W);
      thresh_q <= '0;
    end else if (cfg_we) begin
      case (cfg_kind)
        CFG_PRIO:   prio_q[cfg_line]   <= cfg_data;
        CFG_ENABLE: enable_q[cfg_line] <= cfg_data[0];
        CFG_GROUP:  group_q <= (int'(cfg_data) > PRIO_W) ? GRP_W'(PRIO_W) : GRP_W'(cfg_data);
        default:    thresh_q <= cfg_data;
      endcase
    end
  end

  npic_pending #(.N(N), .IDX_W(IDX_W)) u_pending (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .clr_valid (accept),
    .clr_idx   (win_idx),
    .pending_o (pending)
  );

  npic_arbiter #(.N(N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .pending    (pending),
    .enable     (enable_q),
    .prio       (prio_q),
    .thresh     (thresh_q),
    .found_o    (found),
    .win_idx_o  (win_idx),
    .win_prio_o (win_prio)
  );

  assign win_key       = PRIO_W'(preempt_key(8'(win_prio), PRIO_W, int'(group_q)));
  assign beats_running = stk_empty || (win_key < top_key);
  assign irq_req       = found && beats_running && !stk_full;
  assign irq_vec       = win_idx;
  assign accept        = ack && irq_req;

  npic_level_stack #(.DEPTH(DEPTH), .KEY_W(PRIO_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .pop       (eoi),
    .push_key  (win_key),
    .top_key_o (top_key),
    .empty_o   (stk_empty),
    .full_o    (stk_full)
  );

  p_req_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (enable_q[irq_vec] && pending[irq_vec]))
    else $error("presented line not pending and enabled");

  p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && thresh_q != '0) |-> (prio_q[irq_vec] < thresh_q))
    else $error("masked line presented");

  p_preempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !stk_empty) |->
      (PRIO_W'(preempt_key(8'(prio_q[irq_vec]), PRIO_W, int'(group_q))) < top_key))
    else $error("request does not beat running level");

  p_full_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |-> !irq_req)
    else $error("request while nesting is full");

endmodule

// File: tb/tb_npic_top.sv
`timescale 1ns/1ps
module tb_npic_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [3:0]  cfg_line = '0;
  logic [3:0]  cfg_data = '0;
  logic        ack = 1'b0;
  logic        eoi = 1'b0;
  logic        irq_req;
  logic [3:0]  irq_vec;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  npic_top dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_kind(cfg_kind), .cfg_line(cfg_line), .cfg_data(cfg_data),
    .ack(ack), .eoi(eoi), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expect request state and, if requesting, the vector
  task automatic expect_req(string tag, bit req, int vec);
    check({tag, " req"}, int'(irq_req), int'(req));
    if (req) check({tag, " vec"}, int'(irq_vec), vec);
  endtask

  task automatic do_reset();
    irq_in = '0; ack = 0; eoi = 0; cfg_we = 0;
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
  endtask

  task automatic cfg(int kind, int line, int data);
    cfg_we = 1; cfg_kind = 2'(kind); cfg_line = 4'(line); cfg_data = 4'(data);
    tick();
    cfg_we = 0;
  endtask

  task automatic setline(int line, int p);
    cfg(0, line, p);
    cfg(1, line, 1);
  endtask

  task automatic raise(int line);
    irq_in[line] = 1'b1;
    tick();
  endtask

  task automatic do_ack();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic do_eoi();
    eoi = 1; tick(); eoi = 0;
  endtask

  task automatic t_reset_enable();
    do_reset();
    check("R1 req", int'(irq_req), 0);
    check("R1 vec", int'(irq_vec), 0);
    raise(3);
    expect_req("R3 disabled", 0, 0);
    cfg(1, 3, 1);
    expect_req("R2 R11 pending kept, enable", 1, 3);
  endtask

  task automatic t_order();
    do_reset();
    setline(2, 7); setline(5, 3); setline(9, 3);
    raise(2); raise(5); raise(9);
    expect_req("R4 lowest value", 1, 5);
    do_ack();
    expect_req("R7 equal no preempt", 0, 0);
    do_eoi();
    expect_req("R4 tie lower line", 1, 9);
    do_ack(); do_eoi();
    expect_req("R4 last", 1, 2);
    do_ack(); do_eoi();
    expect_req("R2 held level no relatch", 0, 0);
  endtask

  task automatic t_mask();
    do_reset();
    setline(1, 4); setline(6, 5);
    cfg(3, 0, 4);
    raise(1); raise(6);
    expect_req("R5 both masked", 0, 0);
    cfg(3, 0, 5);
    expect_req("R5 one unmasked", 1, 1);
    cfg(1, 1, 0);
    expect_req("R5 equal masked", 0, 0);
    cfg(3, 0, 0);
    expect_req("R5 zero threshold", 1, 6);
  endtask

  task automatic t_ack();
    do_reset();
    do_ack();
    setline(7, 5);
    raise(7);
    expect_req("R6 stray ack ignored", 1, 7);
    do_ack();
    expect_req("R6 after ack", 0, 0);
    do_eoi();
    expect_req("R6 pending cleared", 0, 0);
  endtask

  task automatic t_nest();
    do_reset();
    setline(4, 6); raise(4); do_ack();
    setline(8, 2); raise(8);
    expect_req("R7 more urgent preempts", 1, 8);
    do_ack();
    expect_req("R7 nested", 0, 0);
    setline(10, 6); raise(10);
    expect_req("R7 above running", 0, 0);
    do_eoi();
    expect_req("R9 level 6 restored", 0, 0);
    do_eoi();
    expect_req("R9 idle restored", 1, 10);
  endtask

  task automatic t_group();
    do_reset();
    cfg(2, 0, 2);
    setline(0, 5); raise(0); do_ack();
    setline(1, 4); raise(1);
    expect_req("R8 subpriority no preempt", 0, 0);
    setline(2, 3); raise(2);
    expect_req("R8 group field preempts", 1, 2);
    do_reset();
    cfg(2, 0, 0);
    setline(0, 9); raise(0); do_ack();
    setline(1, 0); raise(1);
    expect_req("R8 group zero no nesting", 0, 0);
    do_eoi();
    expect_req("R8 after eoi", 1, 1);
    do_reset();
    cfg(2, 0, 7);
    setline(0, 9); raise(0); do_ack();
    setline(1, 8); raise(1);
    expect_req("R8 clamp to 4", 1, 1);
  endtask

  task automatic t_depth();
    do_reset();
    for (int i = 0; i < 4; i++) begin
      setline(i, 14 - 4 * i);
      raise(i);
      expect_req("R10 fill", 1, i);
      do_ack();
    end
    setline(4, 0); raise(4);
    expect_req("R10 full blocks", 0, 0);
    do_eoi();
    expect_req("R10 after pop", 1, 4);
  endtask

  task automatic t_eoi_empty();
    do_reset();
    do_eoi();
    setline(3, 3); raise(3);
    expect_req("R9 eoi on empty ignored", 1, 3);
  endtask

  task automatic t_live_cfg();
    do_reset();
    setline(2, 5); setline(3, 6);
    raise(2); raise(3);
    expect_req("R11 before write", 1, 2);
    cfg(0, 3, 1);
    expect_req("R11 new value next cycle", 1, 3);
    cfg(1, 3, 0);
    expect_req("R11 disable next cycle", 1, 2);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset_enable();
    t_order();
    t_mask();
    t_ack();
    t_nest();
    t_group();
    t_depth();
    t_eoi_empty();
    t_live_cfg();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule